// File: doc/BRIEF.md
# Four-Rail Return-to-Zero Packet Link

This block is a clocked model of a delay-insensitive point-to-point link. The link carries packets as 2-bit symbols. Each symbol raises exactly one of four data rails. A fifth rail marks the end of a packet. A single acknowledge rail runs back from the receiver. The transmitter half takes bytes from a valid/ready stream and cuts each byte into symbols. It then drives each symbol under a four-phase handshake: present the symbol, wait for acknowledge, drop to all-zero, and wait for acknowledge to clear.

The receiver half watches the rails and accepts any single-hot code. It rebuilds the bytes and reports each finished byte together with a flag that says whether the packet ended with it. A code with more than one rail high is flagged as an error and is not acknowledged.

Both halves live in one module. The transmitter's rails and the receiver's rails are separate ports, so a system can join them through any wiring. A test can also place an arbitrary code on the receiving side.

Top module: `quad_rail_link`

## Requirements
- R1: A data symbol of value v (0 to 3) raises only rail bit v of `tx_wires`. So 00 gives 5'b00001, 01 gives 5'b00010, 10 gives 5'b00100 and 11 gives 5'b01000.
- R2: Each byte goes out as DW/2 symbols, starting with bits [1:0] and moving up to the most-significant pair.
- R3: At most one of the five bits of `tx_wires` is high in any cycle.
- R4: The transmitter holds a symbol unchanged until `tx_ack` is high. It then drives all-zero, and a symbol never changes directly into another non-zero code.
- R5: After the null, the transmitter starts no new symbol while `tx_ack` is still high.
- R6: The receiver raises `rx_ack` one cycle after it samples a single-hot code on `rx_wires`. It keeps `rx_ack` high while `rx_wires` is non-zero, and lowers it one cycle after it samples all-zero.
- R7: After the last byte of a packet (`s_last` = 1), the transmitter sends one end-of-packet symbol, which is 5'b10000. It sends none after other bytes.
- R8: `s_ready` is high only while the transmitter is idle and `tx_ack` is low. A byte is taken on a clock edge where `s_valid` and `s_ready` are both high. The rails do not depend on `s_data` at any other time.
- R9: The receiver pulses `m_valid` for one cycle with the rebuilt byte on `m_data`. This happens in the cycle after the edge that accepts the next symbol. `m_last` is 1 when that next symbol is end-of-packet and 0 when it is data.
- R10: If more than one bit of `rx_wires` is high on a clock edge, `err` is high in the following cycle. No acknowledge is given, and the code does not change the byte being rebuilt.
- R11: During reset, `s_ready` is 1 and `tx_wires`, `rx_ack`, `m_valid`, `m_last` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Byte offered to transmitter |
| s_data | input | DW | Byte to transmit |
| s_last | input | 1 | Offered byte ends the packet |
| s_ready | output | 1 | Transmitter can take a byte |
| tx_wires | output | 5 | Outgoing rails: [3:0] data, [4] end-of-packet |
| tx_ack | input | 1 | Acknowledge returned to transmitter |
| rx_wires | input | 5 | Incoming rails: [3:0] data, [4] end-of-packet |
| rx_ack | output | 1 | Acknowledge driven by receiver |
| m_valid | output | 1 | Rebuilt byte present (one-cycle pulse) |
| m_data | output | DW | Rebuilt byte |
| m_last | output | 1 | Rebuilt byte was followed by end-of-packet |
| err | output | 1 | Illegal multi-hot code seen on previous edge |

## Verification
The assertions check the handshake rules on every cycle:
- the transmit rails stay one-hot or null;
- a symbol is held until acknowledged;
- every symbol passes through null;
- no new symbol starts while acknowledge is high;
- the receiver holds acknowledge until null;
- an acknowledge only ever follows a single-hot code;
- a multi-hot code is flagged and never acknowledged.

The data-carrying behaviour can only be shown by the bench's scenarios, with the two halves joined in loopback. These scenarios cover the order of symbols within a byte, the placement of end-of-packet after the last byte only, and the deferred report of each byte with its last flag. They also cover an illegal code injected between two bytes of one packet, which must leave the pending byte intact.

// File: rtl/quad_rail_link.sv
module quad_rail_link #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic [4:0]    tx_wires,
  input  logic          tx_ack,
  input  logic [4:0]    rx_wires,
  output logic          rx_ack,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic          m_last,
  output logic          err
);
  localparam int NS = DW / 2;
  localparam int CW = (NS > 1) ? $clog2(NS) : 1;
  localparam logic [CW-1:0] LASTC = CW'(NS - 1);

  typedef enum logic [2:0] {IDLE, SYM, SYMZ, EOP, EOPZ} tx_st_t;

  tx_st_t        st;
  logic [DW-1:0] sh;
  logic [CW-1:0] tcnt;
  logic          lastq;

  assign s_ready  = (st == IDLE) && !tx_ack;
  assign tx_wires = (st == SYM) ? {1'b0, 4'b0001 << sh[1:0]} :
                    (st == EOP) ? 5'b10000 : 5'b00000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      sh    <= '0;
      tcnt  <= '0;
      lastq <= 1'b0;
    end else begin
      case (st)
        IDLE: if (s_valid && s_ready) begin
          sh    <= s_data;
          lastq <= s_last;
          tcnt  <= '0;
          st    <= SYM;
        end
        SYM:  if (tx_ack) st <= SYMZ;
        SYMZ: if (!tx_ack) begin
          if (tcnt == LASTC) begin
            st <= lastq ? EOP : IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
            sh   <= sh >> 2;
            st   <= SYM;
          end
        end
        EOP:  if (tx_ack) st <= EOPZ;
        EOPZ: if (!tx_ack) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  logic          one, bad;
  logic [1:0]    dv;
  logic [DW-1:0] acc, pbyte, nxt;
  logic [CW-1:0] rcnt;
  logic          pend;

  assign one = $onehot(rx_wires);
  assign bad = $countones(rx_wires) > 1;
  assign dv  = {rx_wires[3] | rx_wires[2], rx_wires[3] | rx_wires[1]};
  assign nxt = {dv, acc[DW-1:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ack  <= 1'b0;
      acc     <= '0;
      pbyte   <= '0;
      rcnt    <= '0;
      pend    <= 1'b0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
      err     <= 1'b0;
    end else begin
      m_valid <= 1'b0;
      m_last  <= 1'b0;
      err     <= bad;
      if (!rx_ack) begin
        if (one) begin
          rx_ack <= 1'b1;
          if (pend) begin
            m_valid <= 1'b1;
            m_data  <= pbyte;
            m_last  <= rx_wires[4];
            pend    <= 1'b0;
          end
          if (rx_wires[4]) begin
            rcnt <= '0;
          end else begin
            acc <= nxt;
            if (rcnt == LASTC) begin
              rcnt  <= '0;
              pend  <= 1'b1;
              pbyte <= nxt;
            end else begin
              rcnt <= rcnt + 1'b1;
            end
          end
        end
      end else if (rx_wires == 5'b00000) begin
        rx_ack <= 1'b0;
      end
    end
  end
endmodule

module quad_rail_link_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic [4:0]    tx_wires,
  input logic          tx_ack,
  input logic [4:0]    rx_wires,
  input logic          rx_ack,
  input logic          m_valid,
  input logic          m_last,
  input logic          err
);
  logic multi;
  assign multi = $countones(rx_wires) > 1;

  // R3
  tx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_wires));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wires != 5'b0 && !tx_ack) |=> $stable(tx_wires));

  // R4
  tx_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wires != 5'b0) |=> (tx_wires == 5'b0 || $stable(tx_wires)));

  // R5
  tx_wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wires == 5'b0 && tx_ack) |=> (tx_wires == 5'b0));

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tx_wires == 5'b0 && !tx_ack));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && rx_wires != 5'b0) |=> rx_ack);

  // R6
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack) |-> $past($onehot(rx_wires)));

  // R10
  rx_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && !rx_ack) |=> (err && !rx_ack));

  // R9
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);
endmodule

bind quad_rail_link quad_rail_link_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_quad_rail_link.sv
module sim_quad_rail_link;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [4:0] tx_wires;
  logic       rx_ack;
  logic       m_valid;
  logic [7:0] m_data;
  logic       m_last;
  logic       err;
  logic       inj_en = 1'b0;
  logic [4:0] inj_val = '0;
  logic [4:0] rx_wires;

  assign rx_wires = inj_en ? inj_val : tx_wires;

  always #2 clk = ~clk;

  quad_rail_link #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .tx_wires(tx_wires), .tx_ack(rx_ack),
    .rx_wires(rx_wires), .rx_ack(rx_ack),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .err(err)
  );

  typedef struct packed {
    logic [4:0] w;
    logic       a;
    logic       mv;
    logic [7:0] md;
    logic       ml;
  } ent_t;

  ent_t q[$];
  ent_t cur = '0;
  bit   cur_busy = 0;
  bit   cur_err = 0;
  bit   pend_v = 0;
  logic [7:0] pend_b = '0;
  int   compared = 0;
  int   mismatched = 0;
  int   cycles = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d, input bit last);
    for (int i = 0; i < 4; i++) begin
      ent_t e;
      logic [4:0] w;
      w = 5'(1) << ((d >> (2 * i)) & 8'h3);
      e = '0; e.w = w; q.push_back(e);
      e = '0; e.w = w; e.a = 1'b1;
      if (i == 0 && pend_v) begin
        e.mv = 1'b1; e.md = pend_b; e.ml = 1'b0; pend_v = 0;
      end
      q.push_back(e);
      e = '0; e.a = 1'b1; q.push_back(e);
      e = '0; q.push_back(e);
    end
    pend_v = 1; pend_b = d;
    if (last) begin
      ent_t e;
      e = '0; e.w = 5'b10000; q.push_back(e);
      e = '0; e.w = 5'b10000; e.a = 1'b1;
      e.mv = 1'b1; e.md = pend_b; e.ml = 1'b1; pend_v = 0;
      q.push_back(e);
      e = '0; e.a = 1'b1; q.push_back(e);
      e = '0; q.push_back(e);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      // R11 reset state
      chk(s_ready == 1'b1, "R11 s_ready", s_ready, 1);
      chk(tx_wires == 5'b0 && rx_ack == 1'b0, "R11 rails/ack", {tx_wires, rx_ack}, 0);
      chk(!m_valid && !m_last && !err, "R11 outputs", {m_valid, m_last, err}, 0);
    end else if (!done) begin
      // R1 R2 R4 R7 symbol stream on the rails
      chk(tx_wires === cur.w, "R1 R2 R4 R7 tx_wires", tx_wires, cur.w);
      // R3
      chk($onehot0(tx_wires), "R3 onehot", tx_wires, 0);
      // R5 R6 acknowledge timing
      chk(rx_ack === cur.a, "R5 R6 rx_ack", rx_ack, cur.a);
      // R8
      chk(s_ready === !cur_busy, "R8 s_ready", s_ready, !cur_busy);
      // R9
      chk(m_valid === cur.mv, "R9 m_valid", m_valid, cur.mv);
      if (cur.mv) begin
        chk(m_data === cur.md, "R2 R9 m_data", m_data, cur.md);
        chk(m_last === cur.ml, "R7 R9 m_last", m_last, cur.ml);
      end
      // R10
      chk(err === cur_err, "R10 err", err, cur_err);
      if (s_valid && !cur_busy) push_byte(s_data, s_last);
      cur_err = inj_en && ($countones(inj_val) > 1);
      if (q.size() > 0) begin
        cur = q.pop_front();
        cur_busy = 1;
      end else begin
        cur = '0;
        cur_busy = 0;
      end
    end
  end

  task automatic send(input logic [7:0] d, input bit last);
    s_valid = 1'b1; s_data = d; s_last = last;
    do @(negedge clk); while (!s_ready);
    @(posedge clk) #1;
    s_valid = 1'b0; s_data = ~d; s_last = ~last;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk) #1;
  endtask

  task automatic wait_idle();
    do @(posedge clk) #1; while (cur_busy || q.size() > 0);
    idle(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);
    // R1 R2 R7: single-byte packet covering all four symbol values
    send(8'hE4, 1'b1);
    wait_idle();
    // R2 R8 R9: three-byte packet offered back to back
    send(8'h00, 1'b0);
    send(8'hFF, 1'b0);
    send(8'h1B, 1'b1);
    wait_idle();
    // R10: illegal codes between two bytes of one packet
    send(8'h6C, 1'b0);
    wait_idle();
    @(posedge clk) #1; inj_en = 1'b1; inj_val = 5'b00011;
    @(posedge clk) #1; inj_val = 5'b10001;
    @(posedge clk) #1; inj_val = 5'b01110;
    @(posedge clk) #1; inj_en = 1'b0; inj_val = 5'b00000;
    idle(3);
    send(8'h93, 1'b1);
    wait_idle();
    // R9: several short packets, varied contents
    for (int i = 0; i < 12; i++) begin
      send(8'(i * 37 + 5), (i % 3) == 2);
    end
    send(8'h5A, 1'b1);
    wait_idle();
    idle(4);
    finish_run();
  end
endmodule